// File: doc/BRIEF.md
# Interrupt Source Gating Register Bank

This block is the front end of an interrupt controller. It merges 32 level-sensitive hardware request lines with a 32-bit set of requests that software raises, and it routes each line to one of two paths. The normal path gates each line with an enable mask. The fast path takes every line whose select bit is set and does not look at the enable mask. A downstream priority engine reads three outputs: the merged raw vector, the gated normal-path vector and a single fast-request line.

Software reaches the block through a small word-addressed register port. Each read has one cycle of latency. The enable and software-request registers each have one address that sets bits and a second address that clears them. A read-only identification area sits at the top of the 4 KiB window.

Top module: `irq_source_gate`

## Requirements
- R1: `raw_vec` equals `src_lvl` OR the software-request register, bit by bit. The raw value is also readable at offset 0x08.
- R2: `irq_vec` equals raw AND enable AND NOT select. It is also readable at offset 0x00.
- R3: The fast-path status equals raw AND select, with no enable gating, and is readable at offset 0x04. `fiq_out` is 1 exactly when any fast-path status bit is 1.
- R4: A write to 0x10 ORs the write data into the enable register, and a write to 0x14 clears the enable bits written as 1. The enable register is read at 0x10.
- R5: A write to 0x18 ORs the write data into the software-request register, and a write to 0x1C clears the bits written as 1. The register is read at 0x18.
- R6: A write to 0x0C replaces the whole select register, which reads back at 0x0C.
- R7: A write to offset 0x00 changes no register and no output.
- R8: A write to 0x20 stores only data bit 0 in the protection flag. A read of 0x20 returns the flag in bit 0 and zeros above it.
- R9: A read at word offsets 0xFE0 to 0xFFC returns, in address order, one byte per word: 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: A read of any other offset returns 0. This includes 0x14, 0x1C and addresses above 0x20 outside the identification area.
- R11: A synchronous reset clears the enable, select, software-request and protection registers and the read data.
- R12: `bus_rdata` takes the value for the address presented with `bus_rd` at the next rising clock edge, and holds that value in cycles without `bus_rd`. A write takes effect at the rising edge where `bus_wr` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lvl | input | 32 | Hardware interrupt levels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_vec | output | 32 | Gated normal-path requests |
| raw_vec | output | 32 | Merged raw requests |
| fiq_out | output | 1 | Any fast-path request |

## Verification
A table of source, software, enable and select combinations drives the gating logic. The combinations are built to separate specific faults. One has lines pending with the enable mask clear, which separates gating from raw merging. One has hardware and software requests on disjoint bits, which exposes a missing OR term. One routes a line to the fast path with its enable off, which catches enable gating wrongly applied to that path. One uses mixed select and enable patterns, where AND and NOT errors give distinct vectors. Directed sequences cover set/clear accumulation, the ignored write, the protection bit, the identification bytes, undecoded reads, reset and read-data holding.

// File: rtl/irq_source_gate.sv
module irq_source_gate #(
  parameter int NSRC = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic [NSRC-1:0] irq_vec,
  output logic [NSRC-1:0] raw_vec,
  output logic            fiq_out
);
  localparam int WA = AW - 2;
  localparam logic [WA-1:0] W_IRQ  = WA'(0);
  localparam logic [WA-1:0] W_FIQ  = WA'(1);
  localparam logic [WA-1:0] W_RAW  = WA'(2);
  localparam logic [WA-1:0] W_SEL  = WA'(3);
  localparam logic [WA-1:0] W_ENS  = WA'(4);
  localparam logic [WA-1:0] W_ENC  = WA'(5);
  localparam logic [WA-1:0] W_SWS  = WA'(6);
  localparam logic [WA-1:0] W_SWC  = WA'(7);
  localparam logic [WA-1:0] W_PROT = WA'(8);
  localparam logic [AW-6:0] ID_BLK = {(AW-5){1'b1}};

  logic [NSRC-1:0] en_r, sel_r, sw_r, fiq_vec, rd_mux;
  logic            prot_r;
  logic [WA-1:0]   widx;
  logic [7:0]      id_byte;

  assign widx    = bus_addr[AW-1:2];
  assign raw_vec = src_lvl | sw_r;
  assign irq_vec = raw_vec & en_r & ~sel_r;
  assign fiq_vec = raw_vec & sel_r;
  assign fiq_out = |fiq_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r   <= '0;
      sel_r  <= '0;
      sw_r   <= '0;
      prot_r <= 1'b0;
    end else if (bus_wr) begin
      case (widx)
        W_SEL:   sel_r  <= bus_wdata;
        W_ENS:   en_r   <= en_r | bus_wdata;
        W_ENC:   en_r   <= en_r & ~bus_wdata;
        W_SWS:   sw_r   <= sw_r | bus_wdata;
        W_SWC:   sw_r   <= sw_r & ~bus_wdata;
        W_PROT:  prot_r <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr[4:2])
      3'd0: id_byte = 8'h90;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr[AW-1:5] == ID_BLK) rd_mux = NSRC'(id_byte);
    else begin
      case (widx)
        W_IRQ:   rd_mux = irq_vec;
        W_FIQ:   rd_mux = fiq_vec;
        W_RAW:   rd_mux = raw_vec;
        W_SEL:   rd_mux = sel_r;
        W_ENS:   rd_mux = en_r;
        W_SWS:   rd_mux = sw_r;
        W_PROT:  rd_mux = NSRC'(prot_r);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

module irq_source_gate_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] bus_rdata,
  input logic [NSRC-1:0] irq_vec,
  input logic [NSRC-1:0] raw_vec,
  input logic            fiq_out,
  input logic [NSRC-1:0] en_r,
  input logic [NSRC-1:0] sel_r,
  input logic [NSRC-1:0] sw_r,
  input logic            prot_r
);
  a_r1_raw_covers_sw: assert property (@(posedge clk) disable iff (rst)
    (sw_r & ~raw_vec) == '0);
  a_r2_irq_gated: assert property (@(posedge clk) disable iff (rst)
    (irq_vec & ~(raw_vec & en_r)) == '0 && (irq_vec & sel_r) == '0);
  a_r3_fiq_needs_raw: assert property (@(posedge clk) disable iff (rst)
    fiq_out |-> (raw_vec != '0 && sel_r != '0));
  a_r4_en_set: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h10)) |=> (en_r & $past(bus_wdata)) == $past(bus_wdata));
  a_r4_en_clr: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h14)) |=> (en_r & $past(bus_wdata)) == '0);
  a_r5_sw_set: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h18)) |=> (sw_r & $past(bus_wdata)) == $past(bus_wdata));
  a_r5_sw_clr: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h1C)) |=> (sw_r & $past(bus_wdata)) == '0);
  a_r6_sel_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h0C)) |=> sel_r == $past(bus_wdata));
  a_r7_zero_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0) |=> $stable({en_r, sel_r, sw_r, prot_r}));
  a_r8_prot_bit: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h20)) |=> prot_r == $past(bus_wdata[0]));
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (en_r == '0 && sel_r == '0 && sw_r == '0 && !prot_r && bus_rdata == '0));
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind irq_source_gate irq_source_gate_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_vec(irq_vec),
  .raw_vec(raw_vec), .fiq_out(fiq_out), .en_r(en_r), .sel_r(sel_r),
  .sw_r(sw_r), .prot_r(prot_r));

// File: tb/irq_source_gate_test.sv
`timescale 1ns/1ps
module irq_source_gate_test;
  logic        clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [31:0] src_lvl = '0, bus_wdata = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_rdata, irq_vec, raw_vec;
  logic        fiq_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_source_gate uut (.clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_vec(irq_vec), .raw_vec(raw_vec), .fiq_out(fiq_out));

  // src, sw, en, sel, raw, irq, fiq-status
  localparam logic [31:0] VEC [6][7] = '{
    '{32'h0,         32'h0,         32'hFFFF_FFFF, 32'h0,         32'h0,         32'h0,         32'h0},
    '{32'h0000_00FF, 32'h0,         32'h0000_000F, 32'h0,         32'h0000_00FF, 32'h0000_000F, 32'h0},
    '{32'h0000_00FF, 32'h0000_FF00, 32'hFFFF_FFFF, 32'h0000_0F0F, 32'h0000_FFFF, 32'h0000_F0F0, 32'h0000_0F0F},
    '{32'h8000_0000, 32'h0,         32'h0,         32'h8000_0000, 32'h8000_0000, 32'h0,         32'h8000_0000},
    '{32'h0,         32'h0001_0000, 32'h0001_0000, 32'h0,         32'h0001_0000, 32'h0001_0000, 32'h0},
    '{32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_0000, 32'h00FF_00FF, 32'hFFFF_FFFF, 32'hFF00_0000, 32'h00FF_00FF}};
  localparam logic [7:0] IDB [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, keep;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 rdata", bus_rdata, 0);
    rd(12'h010, v); check("R11 enable", v, 0);
    rd(12'h00C, v); check("R11 select", v, 0);
    rd(12'h018, v); check("R11 soft", v, 0);
    rd(12'h020, v); check("R11 prot", v, 0);

    for (int i = 0; i < 6; i++) begin
      wr(12'h014, 32'hFFFF_FFFF);
      wr(12'h01C, 32'hFFFF_FFFF);
      wr(12'h00C, VEC[i][3]);
      wr(12'h010, VEC[i][2]);
      wr(12'h018, VEC[i][1]);
      src_lvl = VEC[i][0];
      @(negedge clk);
      check("R1 raw_vec", raw_vec, VEC[i][4]);
      check("R2 irq_vec", irq_vec, VEC[i][5]);
      check("R3 fiq_out", {31'b0, fiq_out}, {31'b0, VEC[i][6] != 0});
      rd(12'h008, v); check("R1 raw read", v, VEC[i][4]);
      rd(12'h000, v); check("R2 irq read", v, VEC[i][5]);
      rd(12'h004, v); check("R3 fiq read", v, VEC[i][6]);
    end

    src_lvl = 0;
    wr(12'h014, 32'hFFFF_FFFF); wr(12'h01C, 32'hFFFF_FFFF); wr(12'h00C, 0);
    // R4 set/clear accumulation
    wr(12'h010, 32'h0F); wr(12'h010, 32'hF0);
    rd(12'h010, v); check("R4 set accumulate", v, 32'hFF);
    wr(12'h014, 32'h3C);
    rd(12'h010, v); check("R4 clear", v, 32'hC3);
    // R5
    wr(12'h018, 32'h0100); wr(12'h018, 32'h0001);
    rd(12'h018, v); check("R5 set accumulate", v, 32'h0101);
    check("R5 raw from soft", raw_vec, 32'h0101);
    wr(12'h01C, 32'h0100);
    rd(12'h018, v); check("R5 clear", v, 32'h0001);
    // R6
    wr(12'h00C, 32'h1234_0000); wr(12'h00C, 32'h0000_0034);
    rd(12'h00C, v); check("R6 select replace", v, 32'h34);
    // R7
    keep = irq_vec;
    wr(12'h000, 32'hFFFF_FFFF);
    check("R7 irq unchanged", irq_vec, keep);
    rd(12'h010, v); check("R7 enable unchanged", v, 32'hC3);
    rd(12'h00C, v); check("R7 select unchanged", v, 32'h34);
    rd(12'h018, v); check("R7 soft unchanged", v, 32'h0001);
    // R8
    wr(12'h020, 32'hFFFF_FFFE);
    rd(12'h020, v); check("R8 bit0 only clear", v, 0);
    wr(12'h020, 32'h0000_0003);
    rd(12'h020, v); check("R8 bit0 only set", v, 1);
    // R9
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(k * 4), v); check("R9 id byte", v, {24'b0, IDB[k]});
    end
    // R10
    rd(12'h014, v); check("R10 enclr read", v, 0);
    rd(12'h01C, v); check("R10 swclr read", v, 0);
    rd(12'h024, v); check("R10 0x24", v, 0);
    rd(12'h800, v); check("R10 0x800", v, 0);
    rd(12'hFDC, v); check("R10 0xFDC", v, 0);
    // R12 hold and latency
    rd(12'h010, v); check("R12 read value", v, 32'hC3);
    wr(12'h010, 32'hFF00_0000);
    check("R12 rdata held", bus_rdata, 32'hC3);
    @(negedge clk); bus_rd = 1; bus_addr = 12'h010;
    check("R12 no early update", bus_rdata, 32'hC3);
    @(negedge clk); bus_rd = 0;
    check("R12 one cycle", bus_rdata, 32'hFF00_00C3);
    // R11 reset clears
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R11 rdata cleared", bus_rdata, 0);
    rd(12'h010, v); check("R11 enable cleared", v, 0);
    rd(12'h00C, v); check("R11 select cleared", v, 0);
    rd(12'h018, v); check("R11 soft cleared", v, 0);
    rd(12'h020, v); check("R11 prot cleared", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule